// File: doc/BRIEF.md
# Four-Lane Seven-to-One Serial Deserializer

This block turns four serial data lanes and one serial frame-clock lane into a 28-bit parallel word at the frame rate. All five lanes arrive already sampled once per bit period by a fast clock that runs at seven times the frame rate. The block's only clock is that fast clock. A frame spans seven consecutive samples. The frame-clock lane is high for the first four samples of a frame and low for the last three. The block uses the rising transition on that lane to find the frame boundary.

Each data lane delivers seven bits per frame, with the lane's most significant bit first. The four seven-bit groups are scattered onto the output word through a fixed, non-contiguous map. The word is published together with a valid flag and a frame-rate strobe. Downstream logic captures the word on the strobe's falling edge.

The block publishes data only after the frame-clock lane has shown two clean frames in a row. It withdraws the data as soon as that lane departs from the expected shape. An active-low shutdown input clears all state and holds every output low while it is asserted.

Top module: `quad_lane_deser`

## Requirements
- R1: A frame starts at the sample in which the frame-clock lane is 1 and its previous sample was 0; the sample before the first sample after shutdown counts as 0. The bit counter resynchronises to that sample, whatever the lane did before.
- R2: Within a frame, the first sample of each data lane is that lane's bit 6 and the seventh sample is its bit 0.
- R3: Lane bits map to output bits as follows (lane bit 0 to 6). Lane 0 (`data_lanes[0]`) goes to 0,1,2,3,4,6,7. Lane 1 goes to 8,9,12,13,14,15,18. Lane 2 goes to 19,20,21,22,24,25,26. Lane 3 goes to 27,5,10,11,16,17,23.
- R4: A clean frame is a start sample followed by the lane pattern 1111000 over its seven samples. `word_vld` first rises in the cycle after the last sample of the second clean frame in a row, and never after a single clean frame.
- R5: While locked, `word_out` takes the new frame's bits in the cycle after each clean frame's last sample. At all other times it holds its value, unless R6 applies.
- R6: A mismatch clears `word_vld` and `word_out` in the next cycle. A mismatch is a frame-clock sample that differs from the expected level, or a missing start sample after a frame's seventh sample.
- R7: `frame_strobe` is high for the four cycles that begin with each word update and low for the following three. It is never high while `word_vld` is low, so its falling edge lies inside a stable word.
- R8: While `shut_n` is 0, `word_out`, `word_vld` and `frame_strobe` are 0 at once, and all state is cleared at each clock edge. After release, two clean frames are needed again before data is published.
- R9: `word_out` is all zeros whenever `word_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate sampling clock, seven cycles per frame |
| shut_n | input | 1 | Active-low shutdown and state clear |
| fclk_lane | input | 1 | Sampled frame-clock lane |
| data_lanes | input | 4 | Sampled serial data lanes, one bit per lane |
| word_out | output | 28 | Mapped parallel word |
| word_vld | output | 1 | Word is valid, frame lock held |
| frame_strobe | output | 1 | Frame-rate strobe, falling edge marks capture |

## Verification
The word update on the seventh sample of a locked frame can fall in the same cycle as the assertion of shutdown. The bench provokes this by pulling `shut_n` low exactly while the last bit of a locked frame is presented. Shutdown must win: all outputs are judged zero in the next cycle, and after release the first clean frame must leave `word_vld` low while the second raises it. A behavioural model compares every output on every cycle, including the cycles around glitches, gaps and misaligned starts on the frame-clock lane.

// File: rtl/qld_pkg.sv
package qld_pkg;

  localparam int unsigned NUM_LANES     = 4;
  localparam int unsigned BITS_PER_LANE = 7;
  localparam int unsigned CLK_HIGH_BITS = 4;
  localparam int unsigned WORD_W        = NUM_LANES * BITS_PER_LANE;

  // Output bit index for each lane bit (lane bit 0 first), see R3
  localparam int unsigned MAP_L0 [BITS_PER_LANE] = '{0, 1, 2, 3, 4, 6, 7};
  localparam int unsigned MAP_L1 [BITS_PER_LANE] = '{8, 9, 12, 13, 14, 15, 18};
  localparam int unsigned MAP_L2 [BITS_PER_LANE] = '{19, 20, 21, 22, 24, 25, 26};
  localparam int unsigned MAP_L3 [BITS_PER_LANE] = '{27, 5, 10, 11, 16, 17, 23};

  function automatic int unsigned out_index(int unsigned lane, int unsigned lbit);
    case (lane)
      0:       return MAP_L0[lbit];
      1:       return MAP_L1[lbit];
      2:       return MAP_L2[lbit];
      default: return MAP_L3[lbit];
    endcase
  endfunction

  // Expected frame-clock level at a position inside the frame
  function automatic logic clk_level(int unsigned pos, int unsigned high_bits);
    return pos < high_bits;
  endfunction

endpackage

// File: rtl/qld_frame_tracker.sv
module qld_frame_tracker
  import qld_pkg::*;
#(
  parameter int unsigned LANE_BITS = BITS_PER_LANE,
  parameter int unsigned HIGH_BITS = CLK_HIGH_BITS
) (
  input  logic clk,
  input  logic shut_n,
  input  logic fclk_lane,
  output logic frame_end,
  output logic good_end,
  output logic mismatch,
  output logic load
);

  localparam int unsigned POS_W = $clog2(LANE_BITS + 1);
  localparam logic [POS_W-1:0] NO_PHASE = POS_W'(LANE_BITS);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(LANE_BITS - 1);

  logic             fclk_d;
  logic [POS_W-1:0] cnt_q;
  logic             clean_q;
  logic             streak_q;

  logic             rise;
  logic [POS_W-1:0] pos_eff;
  logic             clean_eff;
  logic             expect_lvl;

  // R1: a rising sample restarts the frame at position zero
  assign rise       = fclk_lane & ~fclk_d;
  assign pos_eff    = rise ? '0 : cnt_q;
  assign expect_lvl = clk_level(32'(pos_eff), HIGH_BITS);

  // R6: out of phase, or wrong level for the position
  assign mismatch   = (pos_eff == NO_PHASE) || (fclk_lane != expect_lvl);
  assign clean_eff  = (rise | clean_q) & ~mismatch;
  assign frame_end  = (pos_eff == LAST_POS);
  assign good_end   = frame_end & clean_eff;
  // R4: publish only when the frame before was clean as well
  assign load       = good_end & streak_q;

  always_ff @(posedge clk) begin
    if (!shut_n) begin
      fclk_d   <= 1'b0;
      cnt_q    <= NO_PHASE;
      clean_q  <= 1'b0;
      streak_q <= 1'b0;
    end else begin
      fclk_d   <= fclk_lane;
      cnt_q    <= (pos_eff >= LAST_POS) ? NO_PHASE : pos_eff + 1'b1;
      clean_q  <= clean_eff;
      if (good_end)      streak_q <= 1'b1;
      else if (mismatch) streak_q <= 1'b0;
    end
  end

endmodule

// File: rtl/qld_lane_shift.sv
module qld_lane_shift
  import qld_pkg::*;
#(
  parameter int unsigned LANE_BITS = BITS_PER_LANE
) (
  input  logic                 clk,
  input  logic                 shut_n,
  input  logic                 din,
  output logic [LANE_BITS-1:0] frame_bits
);

  logic [LANE_BITS-2:0] sh_q;

  // R2: oldest sample sits at the top, the newest sample is bit 0
  assign frame_bits = {sh_q, din};

  always_ff @(posedge clk) begin
    if (!shut_n) sh_q <= '0;
    else         sh_q <= frame_bits[LANE_BITS-2:0];
  end

endmodule

// File: rtl/qld_bit_router.sv
module qld_bit_router
  import qld_pkg::*;
#(
  parameter int unsigned LANES     = NUM_LANES,
  parameter int unsigned LANE_BITS = BITS_PER_LANE
) (
  input  logic [LANES*LANE_BITS-1:0] lane_bits,
  output logic [LANES*LANE_BITS-1:0] word
);

  // R3: fixed scatter of lane bits onto the word
  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    for (genvar gb = 0; gb < LANE_BITS; gb++) begin : g_bit
      localparam int unsigned DST = out_index(gl, gb);
      assign word[DST] = lane_bits[gl*LANE_BITS + gb];
    end
  end

endmodule

// File: rtl/quad_lane_deser.sv
module quad_lane_deser
  import qld_pkg::*;
#(
  parameter int unsigned LANES     = NUM_LANES,
  parameter int unsigned LANE_BITS = BITS_PER_LANE,
  parameter int unsigned HIGH_BITS = CLK_HIGH_BITS
) (
  input  logic                       clk,
  input  logic                       shut_n,
  input  logic                       fclk_lane,
  input  logic [LANES-1:0]           data_lanes,
  output logic [LANES*LANE_BITS-1:0] word_out,
  output logic                       word_vld,
  output logic                       frame_strobe
);

  localparam int unsigned OUT_W = LANES * LANE_BITS;
  localparam int unsigned AGE_W = $clog2(LANE_BITS + 1);
  localparam logic [AGE_W-1:0] AGE_MAX  = AGE_W'(LANE_BITS);
  localparam logic [AGE_W-1:0] AGE_HIGH = AGE_W'(HIGH_BITS);

  logic             frame_end_w;
  logic             good_end_w;
  logic             mismatch_w;
  logic             load_w;
  logic [OUT_W-1:0] lane_bits_w;
  logic [OUT_W-1:0] mapped_w;

  logic [OUT_W-1:0] word_q;
  logic             vld_q;
  logic [AGE_W-1:0] age_q;

  qld_frame_tracker #(
    .LANE_BITS (LANE_BITS),
    .HIGH_BITS (HIGH_BITS)
  ) u_track (
    .clk       (clk),
    .shut_n    (shut_n),
    .fclk_lane (fclk_lane),
    .frame_end (frame_end_w),
    .good_end  (good_end_w),
    .mismatch  (mismatch_w),
    .load      (load_w)
  );

  for (genvar gl = 0; gl < LANES; gl++) begin : g_shift
    qld_lane_shift #(
      .LANE_BITS (LANE_BITS)
    ) u_shift (
      .clk        (clk),
      .shut_n     (shut_n),
      .din        (data_lanes[gl]),
      .frame_bits (lane_bits_w[gl*LANE_BITS +: LANE_BITS])
    );
  end

  qld_bit_router #(
    .LANES     (LANES),
    .LANE_BITS (LANE_BITS)
  ) u_route (
    .lane_bits (lane_bits_w),
    .word      (mapped_w)
  );

  // R5, R6, R9: the word changes only on a load or on a mismatch
  always_ff @(posedge clk) begin
    if (!shut_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
      age_q  <= AGE_MAX;
    end else begin
      if (load_w) begin
        word_q <= mapped_w;
        vld_q  <= 1'b1;
      end else if (mismatch_w) begin
        word_q <= '0;
        vld_q  <= 1'b0;
      end
      if (load_w)                age_q <= '0;
      else if (age_q != AGE_MAX) age_q <= age_q + 1'b1;
    end
  end

  // R8: shutdown forces the outputs low without waiting for an edge
  assign word_out     = shut_n ? word_q : '0;
  assign word_vld     = shut_n & vld_q;
  // R7: strobe high for the first HIGH_BITS cycles of each word
  assign frame_strobe = shut_n & vld_q & (age_q < AGE_HIGH);

endmodule

// File: rtl/qld_checker.sv
module qld_checker #(
  parameter int unsigned OUT_W = 28
) (
  input logic             clk,
  input logic             shut_n,
  input logic [OUT_W-1:0] word_out,
  input logic             word_vld,
  input logic             frame_strobe,
  input logic             load_w,
  input logic             mismatch_w,
  input logic             frame_end_w
);

  assert_shutdown_zero_R8: assert property (@(posedge clk)
    !shut_n |-> (word_out == '0 && !word_vld && !frame_strobe));

  assert_valid_rise_on_load_R4: assert property (@(posedge clk) disable iff (!shut_n)
    $rose(word_vld) |-> $past(load_w));

  assert_load_on_frame_end_R5: assert property (@(posedge clk) disable iff (!shut_n)
    load_w |-> frame_end_w);

  assert_mismatch_drops_R6: assert property (@(posedge clk) disable iff (!shut_n)
    mismatch_w |=> (!word_vld && word_out == '0));

  assert_word_held_R5: assert property (@(posedge clk) disable iff (!shut_n)
    (!load_w && !mismatch_w) |=> $stable(word_out));

  assert_strobe_needs_valid_R7: assert property (@(posedge clk) disable iff (!shut_n)
    frame_strobe |-> word_vld);

  assert_withheld_R9: assert property (@(posedge clk) disable iff (!shut_n)
    !word_vld |-> (word_out == '0));

endmodule

bind quad_lane_deser qld_checker #(.OUT_W(OUT_W)) u_qld_chk (
  .clk          (clk),
  .shut_n       (shut_n),
  .word_out     (word_out),
  .word_vld     (word_vld),
  .frame_strobe (frame_strobe),
  .load_w       (load_w),
  .mismatch_w   (mismatch_w),
  .frame_end_w  (frame_end_w)
);

// File: tb/tb_quad_lane_deser.sv
module tb_quad_lane_deser;

  logic        clk = 1'b0;
  logic        shut_n = 1'b0;
  logic        fclk = 1'b0;
  logic [3:0]  lanes = '0;
  logic [27:0] word_out;
  logic        word_vld;
  logic        frame_strobe;

  always #4 clk = ~clk;

  quad_lane_deser dut (
    .clk          (clk),
    .shut_n       (shut_n),
    .fclk_lane    (fclk),
    .data_lanes   (lanes),
    .word_out     (word_out),
    .word_vld     (word_vld),
    .frame_strobe (frame_strobe)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int map_tbl [4][7] = '{'{0, 1, 2, 3, 4, 6, 7},
                         '{8, 9, 12, 13, 14, 15, 18},
                         '{19, 20, 21, 22, 24, 25, 26},
                         '{27, 5, 10, 11, 16, 17, 23}};

  task automatic chk(input bit ok, input string tag, input logic [27:0] act, input logic [27:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: position since last rising sample, history queues
  int          m_prev, m_next, m_streak, m_vld, m_age;
  bit          m_clean;
  logic [27:0] m_word;
  int          hist [4][$];

  always @(posedge clk) begin
    if (!shut_n) begin
      m_prev = 0; m_next = 7; m_clean = 0; m_streak = 0;
      m_vld = 0; m_word = '0; m_age = 7;
      for (int l = 0; l < 4; l++) hist[l].delete();
    end else begin
      int p;
      bit rise, bad, clean, loaded;
      for (int l = 0; l < 4; l++) begin
        hist[l].push_back(int'(lanes[l]));
        if (hist[l].size() > 7) void'(hist[l].pop_front());
      end
      rise   = (fclk == 1'b1) && (m_prev == 0);
      p      = rise ? 0 : m_next;
      bad    = (p > 6) || (int'(fclk) != ((p < 4) ? 1 : 0));
      clean  = (rise || m_clean) && !bad;
      loaded = 0;
      if (bad) begin
        m_vld = 0; m_word = '0; m_streak = 0;
      end else if (p == 6 && clean) begin
        if (m_streak != 0) begin
          logic [27:0] w;
          w = '0;
          for (int l = 0; l < 4; l++)
            for (int b = 0; b < 7; b++)
              w[map_tbl[l][b]] = hist[l][6 - b][0];
          m_word = w; m_vld = 1; loaded = 1;
        end
        m_streak = 1;
      end
      if (loaded) m_age = 0;
      else if (m_age < 7) m_age++;
      m_next  = (p >= 6) ? 7 : p + 1;
      m_clean = clean;
      m_prev  = int'(fclk);
    end
  end

  always @(posedge clk) begin
    #2;
    if (!done) begin
      logic [27:0] ew;
      logic        ev, es;
      ew = shut_n ? m_word : '0;
      ev = shut_n && (m_vld != 0);
      es = ev && (m_age < 4);
      chk(word_out == ew, "R3 R5 R9 model word", word_out, ew);
      chk(word_vld == ev, "R4 R6 model valid", 28'(word_vld), 28'(ev));
      chk(frame_strobe == es, "R7 model strobe", 28'(frame_strobe), 28'(es));
    end
  end

  // Drive one bit per lane for every frame sample, starting at a negedge
  task automatic send(input logic [6:0] ck, input logic [27:0] w);
    for (int i = 0; i < 7; i++) begin
      fclk = ck[6 - i];
      for (int l = 0; l < 4; l++) lanes[l] = w[map_tbl[l][6 - i]];
      @(negedge clk);
    end
  endtask

  task automatic send_good(input logic [27:0] w);
    send(7'b1111000, w);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(word_out == '0 && !word_vld && !frame_strobe, "R8 reset state", word_out, '0);
    shut_n = 1'b1;

    send_good(28'h1234567);
    chk(!word_vld, "R4 one frame no lock", 28'(word_vld), 28'h0);
    chk(word_out == '0, "R9 withheld", word_out, 28'h0);
    send_good(28'hA5C3F0E);
    chk(word_vld, "R4 lock after two frames", 28'(word_vld), 28'h1);
    chk(word_out == 28'hA5C3F0E, "R3 mapped word", word_out, 28'hA5C3F0E);
    chk(frame_strobe, "R7 strobe at update", 28'(frame_strobe), 28'h1);

    for (int i = 0; i < 7; i++) begin
      fclk = (i < 4);
      for (int l = 0; l < 4; l++) lanes[l] = 1'b1;
      @(negedge clk);
      chk(frame_strobe == (i < 3 || i == 6), "R7 strobe shape", 28'(frame_strobe), 28'(i < 3 || i == 6));
      if (i < 6) chk(word_out == 28'hA5C3F0E, "R5 word held", word_out, 28'hA5C3F0E);
    end
    chk(word_out == 28'hFFFFFFF, "R5 word all ones", word_out, 28'hFFFFFFF);

    for (int l = 0; l < 4; l++)
      for (int b = 0; b < 7; b++) begin
        logic [27:0] w;
        w = 28'h1 << map_tbl[l][b];
        send_good(w);
        chk(word_out == w, $sformatf("R2 R3 walk lane %0d bit %0d", l, b), word_out, w);
      end

    send(7'b1101000, 28'h0F0F0F0);
    chk(!word_vld && word_out == '0, "R6 glitch drops", word_out, 28'h0);
    send_good(28'h3333333);
    chk(!word_vld, "R4 relock first", 28'(word_vld), 28'h0);
    send_good(28'h6C6C6C6);
    chk(word_vld && word_out == 28'h6C6C6C6, "R4 relock second", word_out, 28'h6C6C6C6);

    fclk = 1'b0; lanes = '0;
    @(negedge clk);
    chk(!word_vld && word_out == '0, "R6 gap drops", word_out, 28'h0);

    foreach (hist[l]) ;
    fclk = 1'b1; @(negedge clk);
    fclk = 1'b1; @(negedge clk);
    fclk = 1'b0; lanes = 4'hF; @(negedge clk);
    fclk = 1'b0; @(negedge clk);
    send_good(28'h0ABCDEF);
    send_good(28'h7654321);
    chk(word_vld && word_out == 28'h7654321, "R1 resync misaligned", word_out, 28'h7654321);

    send_good(28'hBEEF123);
    chk(word_out == 28'hBEEF123, "R5 locked update", word_out, 28'hBEEF123);
    for (int i = 0; i < 7; i++) begin
      fclk = (i < 4);
      for (int l = 0; l < 4; l++) lanes[l] = ~lanes[l];
      if (i == 6) shut_n = 1'b0;
      @(negedge clk);
    end
    chk(word_out == '0 && !word_vld && !frame_strobe, "R8 shutdown wins", word_out, 28'h0);
    lanes = 4'hA; fclk = 1'b1;
    @(negedge clk);
    chk(word_out == '0 && !word_vld, "R8 held low", word_out, 28'h0);
    fclk = 1'b0;
    shut_n = 1'b1;
    send_good(28'h1111111);
    chk(!word_vld, "R8 first frame withheld", 28'(word_vld), 28'h0);
    send_good(28'h2468ACE);
    chk(word_vld && word_out == 28'h2468ACE, "R8 relock after release", word_out, 28'h2468ACE);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule